// File: doc/BRIEF.md
# PCI Device Power State Sequencer

This block follows the power condition of a network controller that sits on a PCI slot. It distinguishes five conditions: fully unpowered, powered only from the auxiliary rail (cold D3), host-commanded sleep (hot D3), powered but not yet set up by the host (uninitialized D0), and normal operation (active D0). It moves between them from three sources: the auxiliary-rail detect, the main power-good signal and the slot reset. Host writes to a two-bit power-state field and a one-cycle "host has configured the device" strobe also drive it.

From the current state it drives the clock enable, the MAC transmit/receive enable, the PHY power-down and PHY reset lines, and a PME-enable bit that the host can write. It also raises a one-cycle interrupt request or PME request when a MAC or PHY wake event arrives in active D0. Register decoding, the MAC, the PHY and the wake-frame detectors are outside the block.

Top module: `pcipm_power_ctrl`

## Requirements
- R1: While `arst_n` is low the block is in the unpowered state (`state_o` = 0). In that state `pm_field` = 11b, `pme_en` = 0, `clk_en` = 0, `mac_trx_en` = 0, `phy_pdown` = 1, `phy_rst` = 0, and there are no requests. The state codes are: unpowered 0, cold D3 1, hot D3 2, uninitialized D0 3, active D0 4.
- R2: In the unpowered state, a rising `aux_det` with `pwr_good` low fires an internal power-on reset. The block enters cold D3, `pm_field` becomes 11b and `pme_en` becomes 0. In cold D3, `phy_pdown` = 1 and `clk_en` = 0.
- R3: Cold D3 is held until `pwr_good` and `host_rst_n` are both high. The block then enters uninitialized D0 with `pm_field` = 00b.
- R4: In uninitialized D0, `clk_en` = 1, `mac_trx_en` = 0, `phy_pdown` = 0 and `pm_field` reads 00b.
- R5: Host writes of the reserved field codes 01b and 10b are ignored. Neither the field nor the state changes.
- R6: Writing 11b to the field in either D0 state, with `pwr_good` and `host_rst_n` high, enters hot D3 with `pm_field` = 11b and `clk_en` = 0.
- R7: Writing 00b in hot D3 enters uninitialized D0. `phy_rst` is then high for exactly PHY_RST_CYCLES cycles.
- R8: A `cfg_done` pulse in uninitialized D0 enters active D0, where `mac_trx_en` = 1 and `clk_en` = 1. A `cfg_done` pulse in any other state has no effect.
- R9: In active D0, a MAC or PHY wake event gives a one-cycle pulse on the next cycle. The pulse is on `pme_req` if `pme_en` = 1 and on `irq_req` otherwise. Outside active D0 a wake event raises neither.
- R10: When `pwr_good` falls with `aux_det` high in hot D3 or either D0 state, the block enters cold D3 with `pm_field` = 11b. `phy_pdown` is set and `phy_rst` pulses for PHY_RST_CYCLES cycles.
- R11: When `pwr_good` falls with `aux_det` low, or both are lost while in cold D3, the block enters the unpowered state.
- R12: A low `host_rst_n` with `pwr_good` high, in hot D3 or active D0, returns the block to uninitialized D0 with `pm_field` = 00b and pulses `phy_rst`. `pme_en` is kept.
- R13: In the unpowered state, a high `pwr_good` fires the power-on reset and enters uninitialized D0 directly with `pme_en` = 0.
- R14: `pme_wr` updates `pme_en` only in hot D3 or either D0 state, and only while `pwr_good` and `host_rst_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| aux_det | input | 1 | Auxiliary rail present |
| pwr_good | input | 1 | Main rail good |
| host_rst_n | input | 1 | Slot reset, active low |
| fld_wr | input | 1 | Host write strobe for the power-state field |
| fld_wdata | input | 2 | Power-state field write value |
| pme_wr | input | 1 | Host write strobe for the PME enable |
| pme_wdata | input | 1 | PME enable write value |
| cfg_done | input | 1 | One-cycle host configured strobe |
| mac_wake | input | 1 | MAC wake event |
| phy_wake | input | 1 | PHY link-change wake event |
| state_o | output | 3 | Current power state code |
| pm_field | output | 2 | Readable power-state field |
| pme_en | output | 1 | PME enable bit |
| clk_en | output | 1 | Internal clock enable |
| mac_trx_en | output | 1 | MAC transmit/receive enable |
| phy_pdown | output | 1 | PHY general power-down |
| phy_rst | output | 1 | PHY reset |
| irq_req | output | 1 | Interrupt request pulse |
| pme_req | output | 1 | PME request pulse |

## Verification
State changes, field updates and PME-enable updates all come from the rising edge on which their stimulus is sampled. The bench drives each stimulus just after an edge and checks the outputs one cycle later, before the next stimulus. Wake requests sit behind one register, so they are checked one edge after the wake input and again one edge after it drops. The PHY reset window is checked at its first cycle, at its last cycle (PHY_RST_CYCLES-1 edges later) and one edge after that, when it must be low.

// File: rtl/pcipm_pkg.sv
package pcipm_pkg;
   typedef enum logic [2:0] {
      PS_OFF   = 3'd0,
      PS_D3C   = 3'd1,
      PS_D3H   = 3'd2,
      PS_D0U   = 3'd3,
      PS_D0A   = 3'd4
   } pm_state_e;

   localparam logic [1:0] FLD_D0 = 2'b00;
   localparam logic [1:0] FLD_D3 = 2'b11;
endpackage

// File: rtl/pcipm_aux_edge.sv
module pcipm_aux_edge (
   input  logic clk,
   input  logic arst_n,
   input  logic aux_det,
   output logic aux_rise
);
   logic aux_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) aux_q <= 1'b0;
      else         aux_q <= aux_det;
   end

   assign aux_rise = aux_det & ~aux_q;
endmodule

// File: rtl/pcipm_state_fsm.sv
module pcipm_state_fsm
   import pcipm_pkg::*;
#(
   parameter int PHY_RST_CYCLES = 4
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       aux_det,
   input  logic       aux_rise,
   input  logic       pwr_good,
   input  logic       host_rst_n,
   input  logic       fld_wr,
   input  logic [1:0] fld_wdata,
   input  logic       cfg_done,
   input  logic [1:0] field_q,
   output pm_state_e  state,
   output logic       por,
   output logic       ld_d3,
   output logic       ld_d0,
   output logic       wr_ok,
   output logic       phy_rst
);
   localparam int CW = $clog2(PHY_RST_CYCLES + 1);

   generate
      if (PHY_RST_CYCLES < 1) begin : g_bad_rst
         $error("PHY_RST_CYCLES must be at least 1");
      end
   endgenerate

   pm_state_e    nxt;
   logic         rst_go;
   logic         powered;
   logic [CW-1:0] rcnt;

   assign powered = (state == PS_D0U) || (state == PS_D0A) || (state == PS_D3H);
   assign wr_ok   = powered && pwr_good && host_rst_n;

   always_comb begin
      nxt    = state;
      por    = 1'b0;
      ld_d3  = 1'b0;
      ld_d0  = 1'b0;
      rst_go = 1'b0;
      unique case (state)
         PS_OFF: begin
            if (aux_rise && !pwr_good) begin
               nxt = PS_D3C; por = 1'b1; ld_d3 = 1'b1;
            end else if (pwr_good) begin
               nxt = PS_D0U; por = 1'b1; ld_d0 = 1'b1;
            end
         end
         PS_D3C: begin
            if (!aux_det && !pwr_good) begin
               nxt = PS_OFF;
            end else if (pwr_good && host_rst_n) begin
               nxt = PS_D0U; ld_d0 = 1'b1;
            end
         end
         PS_D0U, PS_D0A, PS_D3H: begin
            if (!pwr_good) begin
               if (aux_det) begin
                  nxt = PS_D3C; ld_d3 = 1'b1; rst_go = 1'b1;
               end else begin
                  nxt = PS_OFF;
               end
            end else if (!host_rst_n) begin
               nxt = PS_D0U; ld_d0 = 1'b1; rst_go = (state != PS_D0U);
            end else if (fld_wr && fld_wdata == FLD_D3 && state != PS_D3H) begin
               nxt = PS_D3H;
            end else if (fld_wr && fld_wdata == FLD_D0 && state == PS_D3H) begin
               nxt = PS_D0U; rst_go = 1'b1;
            end else if (cfg_done && state == PS_D0U && field_q == FLD_D0) begin
               nxt = PS_D0A;
            end
         end
         default: nxt = PS_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state <= PS_OFF;
         rcnt  <= '0;
      end else begin
         state <= nxt;
         if (rst_go)          rcnt <= CW'(PHY_RST_CYCLES);
         else if (rcnt != '0) rcnt <= rcnt - 1'b1;
      end
   end

   assign phy_rst = (rcnt != '0);

   a_r7_wake_from_hot: assert property (@(posedge clk) disable iff (!arst_n)
      (state == PS_D3H && pwr_good && host_rst_n && fld_wr && fld_wdata == FLD_D0)
      |=> (state == PS_D0U && phy_rst));

   a_r10_pg_loss_aux: assert property (@(posedge clk) disable iff (!arst_n)
      (powered && !pwr_good && aux_det) |=> (state == PS_D3C && phy_rst));

   a_r11_pg_loss_noaux: assert property (@(posedge clk) disable iff (!arst_n)
      (powered && !pwr_good && !aux_det) |=> (state == PS_OFF));

   a_r3_cold_hold: assert property (@(posedge clk) disable iff (!arst_n)
      (state == PS_D3C && aux_det && !(pwr_good && host_rst_n)) |=> (state == PS_D3C));
endmodule

// File: rtl/pcipm_regs.sv
module pcipm_regs
   import pcipm_pkg::*;
(
   input  logic       clk,
   input  logic       arst_n,
   input  logic       por,
   input  logic       ld_d3,
   input  logic       ld_d0,
   input  logic       wr_ok,
   input  logic       fld_wr,
   input  logic [1:0] fld_wdata,
   input  logic       pme_wr,
   input  logic       pme_wdata,
   output logic [1:0] field_q,
   output logic       pme_en
);
   logic legal_code;
   assign legal_code = (fld_wdata == FLD_D0) || (fld_wdata == FLD_D3);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         field_q <= FLD_D3;
         pme_en  <= 1'b0;
      end else begin
         if (ld_d3)                           field_q <= FLD_D3;
         else if (ld_d0)                      field_q <= FLD_D0;
         else if (wr_ok && fld_wr && legal_code) field_q <= fld_wdata;

         if (por)                 pme_en <= 1'b0;
         else if (wr_ok && pme_wr) pme_en <= pme_wdata;
      end
   end

   a_r5_reserved_ignored: assert property (@(posedge clk) disable iff (!arst_n)
      (fld_wr && !legal_code && !ld_d3 && !ld_d0) |=> $stable(field_q));

   a_r14_pme_locked: assert property (@(posedge clk) disable iff (!arst_n)
      (!wr_ok && !por) |=> $stable(pme_en));
endmodule

// File: rtl/pcipm_wake_req.sv
module pcipm_wake_req #(
   parameter bit WAKE_REG = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic in_d0a,
   input  logic pme_en,
   input  logic mac_wake,
   input  logic phy_wake,
   output logic irq_req,
   output logic pme_req
);
   logic hit;
   assign hit = in_d0a && (mac_wake || phy_wake);

   generate
      if (WAKE_REG) begin : g_reg
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
               irq_req <= 1'b0;
               pme_req <= 1'b0;
            end else begin
               irq_req <= hit && !pme_en;
               pme_req <= hit && pme_en;
            end
         end

         a_r9_req_only_active: assert property (@(posedge clk) disable iff (!arst_n)
            (irq_req || pme_req) |-> $past(in_d0a));
      end else begin : g_comb
         assign irq_req = hit && !pme_en;
         assign pme_req = hit && pme_en;
      end
   endgenerate

   a_r9_one_kind: assert property (@(posedge clk) disable iff (!arst_n)
      !(irq_req && pme_req));
endmodule

// File: rtl/pcipm_power_ctrl.sv
module pcipm_power_ctrl
   import pcipm_pkg::*;
#(
   parameter int PHY_RST_CYCLES = 4,
   parameter bit WAKE_REG       = 1'b1
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       aux_det,
   input  logic       pwr_good,
   input  logic       host_rst_n,
   input  logic       fld_wr,
   input  logic [1:0] fld_wdata,
   input  logic       pme_wr,
   input  logic       pme_wdata,
   input  logic       cfg_done,
   input  logic       mac_wake,
   input  logic       phy_wake,
   output logic [2:0] state_o,
   output logic [1:0] pm_field,
   output logic       pme_en,
   output logic       clk_en,
   output logic       mac_trx_en,
   output logic       phy_pdown,
   output logic       phy_rst,
   output logic       irq_req,
   output logic       pme_req
);
   pm_state_e state;
   logic      aux_rise, por, ld_d3, ld_d0, wr_ok;

   pcipm_aux_edge u_edge (
      .clk(clk), .arst_n(arst_n), .aux_det(aux_det), .aux_rise(aux_rise)
   );

   pcipm_state_fsm #(.PHY_RST_CYCLES(PHY_RST_CYCLES)) u_fsm (
      .clk(clk), .arst_n(arst_n), .aux_det(aux_det), .aux_rise(aux_rise),
      .pwr_good(pwr_good), .host_rst_n(host_rst_n), .fld_wr(fld_wr),
      .fld_wdata(fld_wdata), .cfg_done(cfg_done), .field_q(pm_field),
      .state(state), .por(por), .ld_d3(ld_d3), .ld_d0(ld_d0),
      .wr_ok(wr_ok), .phy_rst(phy_rst)
   );

   pcipm_regs u_regs (
      .clk(clk), .arst_n(arst_n), .por(por), .ld_d3(ld_d3), .ld_d0(ld_d0),
      .wr_ok(wr_ok), .fld_wr(fld_wr), .fld_wdata(fld_wdata),
      .pme_wr(pme_wr), .pme_wdata(pme_wdata),
      .field_q(pm_field), .pme_en(pme_en)
   );

   pcipm_wake_req #(.WAKE_REG(WAKE_REG)) u_wake (
      .clk(clk), .arst_n(arst_n), .in_d0a(state == PS_D0A), .pme_en(pme_en),
      .mac_wake(mac_wake), .phy_wake(phy_wake),
      .irq_req(irq_req), .pme_req(pme_req)
   );

   assign state_o    = state;
   assign clk_en     = (state == PS_D0U) || (state == PS_D0A);
   assign mac_trx_en = (state == PS_D0A);
   assign phy_pdown  = (state == PS_OFF) || (state == PS_D3C);

   a_r8_active_consistent: assert property (@(posedge clk) disable iff (!arst_n)
      mac_trx_en |-> (pm_field == FLD_D0));

   a_r2_por_cold: assert property (@(posedge clk) disable iff (!arst_n)
      (state == PS_OFF && aux_rise && !pwr_good) |=> (pm_field == FLD_D3 && !pme_en));

   a_r13_por_main: assert property (@(posedge clk) disable iff (!arst_n)
      (state == PS_OFF && pwr_good) |=> (state == PS_D0U && !pme_en));
endmodule

// File: tb/pcipm_power_ctrl_test.sv
module pcipm_power_ctrl_test;
   localparam int NRST = 4;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic aux_det = 0, pwr_good = 0, host_rst_n = 0;
   logic fld_wr = 0, pme_wr = 0, pme_wdata = 0, cfg_done = 0;
   logic mac_wake = 0, phy_wake = 0;
   logic [1:0] fld_wdata = 2'b00;
   logic [2:0] state_o;
   logic [1:0] pm_field;
   logic pme_en, clk_en, mac_trx_en, phy_pdown, phy_rst, irq_req, pme_req;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pcipm_power_ctrl #(.PHY_RST_CYCLES(NRST)) uut (
      .clk(clk), .arst_n(arst_n), .aux_det(aux_det), .pwr_good(pwr_good),
      .host_rst_n(host_rst_n), .fld_wr(fld_wr), .fld_wdata(fld_wdata),
      .pme_wr(pme_wr), .pme_wdata(pme_wdata), .cfg_done(cfg_done),
      .mac_wake(mac_wake), .phy_wake(phy_wake), .state_o(state_o),
      .pm_field(pm_field), .pme_en(pme_en), .clk_en(clk_en),
      .mac_trx_en(mac_trx_en), .phy_pdown(phy_pdown), .phy_rst(phy_rst),
      .irq_req(irq_req), .pme_req(pme_req)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr_field(input logic [1:0] v);
      fld_wr = 1; fld_wdata = v; step(1); fld_wr = 0;
   endtask

   task automatic wr_pme(input logic v);
      pme_wr = 1; pme_wdata = v; step(1); pme_wr = 0;
   endtask

   task automatic t_reset;
      chk("R1 state", state_o, 0);
      chk("R1 field", pm_field, 3);
      chk("R1 pme_en", pme_en, 0);
      chk("R1 clk_en", clk_en, 0);
      chk("R1 pdown", phy_pdown, 1);
      chk("R1 reqs", {phy_rst, irq_req, pme_req, mac_trx_en}, 0);
   endtask

   task automatic t_cold_boot;
      aux_det = 1; step(1);
      chk("R2 state", state_o, 1);
      chk("R2 field", pm_field, 3);
      chk("R2 pme_en", pme_en, 0);
      chk("R2 pdown/clk", {phy_pdown, clk_en}, 2'b10);
      pwr_good = 1; step(2);
      chk("R3 hold under slot reset", state_o, 1);
      host_rst_n = 1; step(1);
      chk("R3 state", state_o, 3);
      chk("R3 field", pm_field, 0);
      chk("R4 outputs", {clk_en, mac_trx_en, phy_pdown}, 3'b100);
   endtask

   task automatic t_reserved;
      wr_field(2'b01);
      chk("R5 field 01", pm_field, 0);
      chk("R5 state 01", state_o, 3);
      wr_field(2'b10);
      chk("R5 field 10", pm_field, 0);
      chk("R5 state 10", state_o, 3);
   endtask

   task automatic t_pme_write;
      wr_pme(1);
      chk("R14 write accepted", pme_en, 1);
      host_rst_n = 0; wr_pme(0);
      chk("R14 write blocked", pme_en, 1);
      host_rst_n = 1; step(1);
   endtask

   task automatic t_hot;
      wr_field(2'b11);
      chk("R6 state", state_o, 2);
      chk("R6 field", pm_field, 3);
      chk("R6 clk_en", clk_en, 0);
      cfg_done = 1; step(1); cfg_done = 0;
      chk("R8 cfg ignored in hot", state_o, 2);
      wr_field(2'b00);
      chk("R7 state", state_o, 3);
      chk("R7 rst first", phy_rst, 1);
      step(NRST - 1);
      chk("R7 rst last", phy_rst, 1);
      step(1);
      chk("R7 rst end", phy_rst, 0);
   endtask

   task automatic t_active_wake;
      mac_wake = 1; step(1); mac_wake = 0;
      chk("R9 no req in D0U", {irq_req, pme_req}, 0);
      cfg_done = 1; step(1); cfg_done = 0;
      chk("R8 state", state_o, 4);
      chk("R8 mac/clk", {mac_trx_en, clk_en}, 2'b11);
      mac_wake = 1; step(1); mac_wake = 0;
      chk("R9 pme path", {irq_req, pme_req}, 2'b01);
      step(1);
      chk("R9 pulse ends", {irq_req, pme_req}, 0);
      wr_pme(0);
      phy_wake = 1; step(1); phy_wake = 0;
      chk("R9 irq path", {irq_req, pme_req}, 2'b10);
   endtask

   task automatic t_slot_reset;
      wr_pme(1);
      host_rst_n = 0; step(1);
      chk("R12 state", state_o, 3);
      chk("R12 field", pm_field, 0);
      chk("R12 phy_rst", phy_rst, 1);
      chk("R12 pme kept", pme_en, 1);
      host_rst_n = 1; step(NRST);
   endtask

   task automatic t_power_loss;
      cfg_done = 1; step(1); cfg_done = 0;
      pwr_good = 0; step(1);
      chk("R10 state", state_o, 1);
      chk("R10 field", pm_field, 3);
      chk("R10 pdown/rst", {phy_pdown, phy_rst}, 2'b11);
      aux_det = 0; step(1);
      chk("R11 cold to off", state_o, 0);
      pwr_good = 1; step(1);
      chk("R13 state", state_o, 3);
      chk("R13 pme cleared", pme_en, 0);
      wr_pme(1);
      pwr_good = 0; step(1);
      chk("R11 no aux", state_o, 0);
   endtask

   initial begin
      step(3);
      arst_n = 1;
      t_reset();
      step(1);
      t_cold_boot();
      t_reserved();
      t_pme_write();
      t_hot();
      t_active_wake();
      t_slot_reset();
      t_power_loss();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule